// File: doc/BRIEF.md
# Serial EEPROM Emulation Slave (Two-Wire Bus)

This block makes a chip look like a small byte-addressed serial EEPROM on a two-wire bus (SCL clock, SDA data, open-drain). A bus master selects the block with a fixed 7-bit device identifier. It can then load an 8-bit location pointer and write a short burst of bytes, or read bytes back as a stream. The storage is a register array inside the block. Write bursts are collected in a one-page staging buffer and moved into the array only when the master closes the transaction with a stop condition.

Both bus lines enter through a two-flop synchroniser that runs on the system clock. The block samples SDA when the synchronised SCL rises and changes its own SDA drive only after a synchronised SCL fall. The single output `sda_oe` pulls SDA low when it is high, and the pad is released when it is low. The location pointer is kept from one transaction to the next, so a read that sends only the device byte continues where the last access stopped.

Top module: `i2c_ee_slave`

## Requirements
- R1: The first byte after a start is compared with the device byte. 0xA0 (identifier 0x50, direction bit 0 = write) and 0xA1 (direction bit 1 = read) are acknowledged. Any other byte gets no acknowledge, and the block keeps SDA released, ignoring all clocks until the next start or stop.
- R2: In a write transaction, the byte after 0xA0 loads the 8-bit pointer. Every later byte is data for the location the pointer selects.
- R3: During a write, only pointer bits [2:0] advance after each data byte, and bits [7:5... ] that is bits [7:3], stay fixed. A burst longer than 8 bytes wraps inside its 8-byte page, and the later bytes overwrite the earlier ones.
- R4: During a read, the whole 8-bit pointer advances after each byte, so 0xFF is followed by 0x00 and one transaction can stream the entire 256-byte array.
- R5: A read that starts with 0xA1 and has no pointer byte returns the location after the last one written (page rule) or read (full increment).
- R6: After each byte it receives and accepts, the block holds SDA low for the whole high period of the ninth clock.
- R7: While sending, the block releases SDA for the ninth clock. If the master leaves SDA high there (no acknowledge), the block sends nothing more until a start or stop.
- R8: A start condition (SDA falling while SCL is high) restarts the byte sequence at any point, including part way through a byte. A stop condition (SDA rising while SCL is high) ends the transaction.
- R9: Written bytes reach the array only on a stop. If a write carries data bytes and then ends with a repeated start, the data is dropped and the pointer holds the word address.
- R10: SDA drive changes only in response to a synchronised SCL fall, start or stop, and stays constant while SCL is high.
- R11: After reset, SDA is released, every array byte reads 0x00 and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for the synchronisers and all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low; low releases the line |

## Verification
The hardest case to reach is a write that is dropped. This needs a complete data byte that the block has acknowledged and buffered, followed by a repeated start instead of a stop. The bench sends that sequence and at once reads through the new start. This shows both that the array kept its old byte and that the pointer stayed at the word address. A repeated start placed half way through a byte, and a full 256-byte write-then-read sweep, cover the remaining edges of the pointer rules.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEV  = 3'd1,
    ST_WADR = 3'd2,
    ST_WDAT = 3'd3,
    ST_RDAT = 3'd4
  } ee_state_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stg[s] <= stg[s-1];
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_ee_cond.sv
module i2c_ee_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave #(
  parameter logic [6:0] DEV_ID      = 7'h50,
  parameter int         AW          = 8,
  parameter int         PW          = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2c_ee_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;

  function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
    logic [PW-1:0] lo;
    lo = a[PW-1:0] + 1'b1;
    return {a[AW-1:PW], lo};
  endfunction

  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic [1:0] sync_q;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  i2c_ee_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  i2c_ee_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  ee_state_t     st;
  logic [3:0]    bit_cnt;
  logic          in_ack, ack_drv, rd_go;
  logic [7:0]    rx_sr, tx_sr;
  logic [AW-1:0] ptr, wr_ptr;
  logic [7:0]    pbuf [PAGE];
  logic [PAGE-1:0] pvld;
  logic [7:0]    mem  [DEPTH];

  // Named internal events for the checker
  logic ack_entry, ack_exit, dev_hit, commit_evt;
  assign ack_entry  = scl_fall & ~in_ack & (bit_cnt == 4'd8) & (st != ST_IDLE);
  assign ack_exit   = scl_fall & in_ack;
  assign dev_hit    = (rx_sr[7:1] == DEV_ID);
  assign commit_evt = stop_evt & (|pvld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      rd_go   <= 1'b0;
      rx_sr   <= '0;
      tx_sr   <= '1;
      ptr     <= '0;
      wr_ptr  <= '0;
      pvld    <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (start_evt) begin
      st      <= ST_DEV;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      pvld    <= '0;
    end else if (stop_evt) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      pvld    <= '0;
      if (|pvld) ptr <= wr_ptr;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (!in_ack && bit_cnt < 4'd8) begin
          rx_sr   <= {rx_sr[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end
        if (in_ack) rd_go <= ~sda_s | ack_drv;
      end
      if (ack_entry) begin
        in_ack <= 1'b1;
        unique case (st)
          ST_DEV: begin
            if (dev_hit) begin
              ack_drv <= 1'b1;
              st      <= rx_sr[0] ? ST_RDAT : ST_WADR;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_WADR: begin
            ack_drv <= 1'b1;
            ptr     <= rx_sr[AW-1:0];
            wr_ptr  <= rx_sr[AW-1:0];
            st      <= ST_WDAT;
          end
          ST_WDAT: begin
            ack_drv              <= 1'b1;
            pbuf[wr_ptr[PW-1:0]] <= rx_sr;
            pvld[wr_ptr[PW-1:0]] <= 1'b1;
            wr_ptr               <= page_next(wr_ptr);
          end
          default: ;
        endcase
      end else if (ack_exit) begin
        in_ack  <= 1'b0;
        ack_drv <= 1'b0;
        bit_cnt <= '0;
        if (st == ST_RDAT) begin
          if (rd_go) begin
            tx_sr <= mem[ptr];
            ptr   <= seq_next(ptr);
          end else begin
            st <= ST_IDLE;
          end
        end
      end else if (scl_fall && st == ST_RDAT && bit_cnt != 4'd0) begin
        tx_sr <= {tx_sr[6:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit_evt) begin
      for (int i = 0; i < PAGE; i++)
        if (pvld[i]) mem[{wr_ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
    end
  end

  assign sda_oe = ack_drv | ((st == ST_RDAT) & ~in_ack & ~tx_sr[7]);
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk #(
  parameter int AW = 8,
  parameter int PW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_fall,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  sda_oe,
  input logic                  ack_drv,
  input logic                  in_ack,
  input i2c_ee_pkg::ee_state_t st,
  input logic [AW-1:0]         wr_ptr
);
  import i2c_ee_pkg::*;

  assert_sda_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_drv) |-> $past(scl_fall || start_evt || stop_evt));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDAT && $past(st == ST_WDAT)) |->
      (wr_ptr[AW-1:PW] == $past(wr_ptr[AW-1:PW])));

  assert_tx_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDAT && !in_ack) |-> !ack_drv);

  assert_start_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_DEV && !sda_oe));
endmodule

bind i2c_ee_slave i2c_ee_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .ack_drv(ack_drv), .in_ack(in_ack),
  .st(st), .wr_ptr(wr_ptr)
);

// File: tb/i2c_ee_slave_bench.sv
module i2c_ee_slave_bench;
  localparam int CLK_P = 10;
  localparam int H     = 6;
  localparam int Q     = 2;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [0:255];
  logic [7:0] exp_ptr;
  logic [7:0] wbuf [0:15];

  always #(CLK_P/2) clk = ~clk;

  i2c_ee_slave u_i2c_ee_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] pg(input logic [7:0] a);
    return (a & 8'hF8) | ((a + 8'd1) & 8'h07);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; cyc(H); scl = 1'b1; cyc(H); sda_m = 1'b0; cyc(H); scl = 1'b0; cyc(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; cyc(H); scl = 1'b1; cyc(H); sda_m = 1'b1; cyc(H);
  endtask

  // one clock pulse; checks the slave drive is steady across the high phase (R10)
  task automatic clk_bit(input logic b, output logic s);
    logic o0;
    sda_m = b; cyc(H); scl = 1'b1; cyc(1); o0 = sda_oe;
    cyc(H/2 - 1); s = sda_bus; cyc(H/2 - 1);
    chk("R10 sda steady while scl high", sda_oe, o0);
    cyc(1); scl = 1'b0; cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s, a0, a1;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    sda_m = 1'b1; cyc(H); scl = 1'b1; cyc(1); a0 = sda_bus;
    cyc(H - 2); a1 = sda_bus; cyc(1); scl = 1'b0; cyc(Q);
    ack = (a0 == 1'b0) && (a1 == 1'b0);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(~mack, s);
    sda_m = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] p;
    start_c();
    send_byte(8'hA0, ack); chk("R1 write select ack", ack, 1);
    send_byte(a, ack);     chk("R2 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk({"R6 data ack ", tag}, ack, 1);
    end
    stop_c();
    if (n > 0) begin
      p = a;
      for (int k = 0; k < n; k++) begin exp_mem[p] = wbuf[k]; p = pg(p); end
      exp_ptr = p;
    end else begin
      exp_ptr = a;
    end
  endtask

  task automatic rd_body(input int n, input string tag);
    logic [7:0] b;
    logic s;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(tag, b, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    clk_bit(1'b1, s);
    chk("R7 released after master nack", s, 1);
    stop_c();
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n, input string tag);
    logic ack;
    start_c();
    send_byte(8'hA0, ack); chk("R1 dummy write ack", ack, 1);
    send_byte(a, ack);     chk("R2 pointer load ack", ack, 1);
    start_c();
    send_byte(8'hA1, ack); chk("R1 read select ack", ack, 1);
    exp_ptr = a;
    rd_body(n, tag);
  endtask

  task automatic rd_cur(input int n, input string tag);
    logic ack;
    start_c();
    send_byte(8'hA1, ack); chk("R1 read select ack", ack, 1);
    rd_body(n, tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack, s;
    logic [7:0] b;
    for (int a = 0; a < 256; a++) exp_mem[a] = 8'h00;
    exp_ptr = 8'h00;
    cyc(5); rst_n = 1'b1; cyc(10);

    // R11: reset state
    chk("R11 sda released after reset", sda_oe, 0);
    rd_cur(4, "R11 array zero, pointer zero");

    // R1: foreign device byte is ignored until stop
    start_c();
    send_byte(8'hA2, ack); chk("R1 foreign address not acked", ack, 0);
    send_byte(8'h55, ack); chk("R1 ignored after mismatch", ack, 0);
    clk_bit(1'b1, s);      chk("R1 sda released after mismatch", s, 1);
    stop_c();
    rd_cur(1, "R1 pointer untouched by foreign address");

    // R2: single write then random read
    wbuf[0] = 8'h5A;
    wr(8'h10, 1, "R2");
    rd_rand(8'h10, 1, "R2 single byte written");

    // R3: page wrap in write
    for (int k = 0; k < 5; k++) wbuf[k] = 8'hC0 + 8'(k);
    wr(8'h1D, 5, "R3");
    rd_rand(8'h18, 8, "R3 page wrap");
    for (int k = 0; k < 10; k++) wbuf[k] = 8'h30 + 8'(k);
    wr(8'h22, 10, "R3");
    rd_rand(8'h20, 8, "R3 overwrite after wrap");

    // R5: current-address after write (page rule) and after read
    wbuf[0] = 8'h77; wbuf[1] = 8'h78;
    wr(8'h67, 2, "R5");
    rd_cur(2, "R5 current address after write");
    rd_cur(1, "R5 current address after read");

    // R8: repeated start part way through a data byte
    wbuf[0] = 8'h91;
    wr(8'h40, 1, "R8");
    start_c();
    send_byte(8'hA0, ack); chk("R8 select ack", ack, 1);
    send_byte(8'h40, ack); chk("R8 address ack", ack, 1);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    start_c();
    send_byte(8'hA1, ack); chk("R8 select after repeated start", ack, 1);
    exp_ptr = 8'h40;
    rd_body(1, "R8 read after mid-byte restart");

    // R9: full data bytes then repeated start: dropped
    start_c();
    send_byte(8'hA0, ack); chk("R9 select ack", ack, 1);
    send_byte(8'h48, ack); chk("R9 address ack", ack, 1);
    send_byte(8'hEE, ack); chk("R9 data ack", ack, 1);
    send_byte(8'hDD, ack); chk("R9 data ack", ack, 1);
    start_c();
    send_byte(8'hA1, ack); chk("R9 select after restart", ack, 1);
    exp_ptr = 8'h48;
    rd_body(1, "R9 dropped write leaves old byte at word address");
    rd_rand(8'h48, 2, "R9 array unchanged");

    // R4: full sweep, 32 page writes, one 256-byte read, wrap past 0xFF
    for (int pgi = 0; pgi < 32; pgi++) begin
      for (int k = 0; k < 8; k++) wbuf[k] = 8'((pgi * 8 + k) * 37 + 11);
      wr(8'(pgi * 8), 8, "R4 sweep");
    end
    rd_rand(8'h00, 256, "R4 sequential full read");
    rd_cur(2, "R4 pointer wrapped to 0x00");
    rd_rand(8'hFE, 4, "R4 read across 0xFF");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule